// File: doc/BRIEF.md
# Floppy Controller Command Dispatch and Interrupt Unit

This unit stands between the host's command register write path and the execution engines of a floppy disk controller. Each byte the host writes as a command is sorted by its upper nibble into one of four classes: head positioning (type I), sector transfer (type II), whole-track or address transfer (type III) and the force-interrupt command (type IV). The unit decides whether the command may start. It then either fires a one-cycle start strobe towards the matching engine or ends the command at once with an interrupt.

The unit owns the busy flag and the interrupt request line. A force-interrupt command is accepted even while another command runs. It aborts the running command and arms interrupt conditions on edges of the drive ready line, on index pulses, or unconditionally. The unit also keeps the track-43 boundary output, which it refreshes each time a transfer command arrives. The host clears a pending interrupt by reading status or by writing the next command.

Top module: `fdc_cmd_dispatch`

## Requirements
- R1: While busy is 1, a command write whose bits 7..4 are not 1101 is ignored: no start strobe fires and busy, the held command byte and the status outputs keep their values.
- R2: Bits 7..4 of an accepted command pick its class. 0xxx is type I (`start_pos`). 1000, 1001, 1010 and 1011 are type II (`start_sect`). 1100, 1110 and 1111 are type III (`start_trk`). 1101 is force interrupt. The strobe lasts one cycle, appears the cycle after the write, and `cmd_byte` then holds the accepted byte.
- R3: A type II or III command written while `ready_i` is 0 does not start. In the next cycle `intrq_o` is 1 and `busy_o` stays 0.
- R4: A type I command starts whatever the level of `ready_i`.
- R5: A write-class command (bits 7..4 of 1010, 1011 or 1111) with `ready_i` high and `wprot_n` low does not start. In the next cycle `intrq_o` and `wprot_stat` are both 1. Every accepted non-force command sets `wprot_stat` to 1 only when it is rejected this way, and to 0 otherwise.
- R6: Each accepted type II or III command, started or rejected, loads `tg43_o` with (`track_i` >= 44). Type I commands leave `tg43_o` unchanged. `tg43_o` is 0 after reset.
- R7: `busy_o` goes to 1 in the cycle after a command starts. When `eng_done` is seen while busy, the next cycle shows `busy_o` = 0 and `intrq_o` = 1.
- R8: A pending interrupt is cleared one cycle after `stat_rd` is pulsed, or one cycle after any accepted command write, unless an interrupt cause is raised in the same cycle.
- R9: Force interrupt (bits 7..4 = 1101) is accepted at any time. If a command is running, `abort_o` pulses for one cycle and `busy_o` clears. With condition bits 3..0 all zero, no interrupt is raised.
- R10: Force interrupt condition bit 0 raises `intrq_o` on a low-to-high change of `ready_i`, bit 1 on a high-to-low change, and bit 2 on a rising edge of `index_i`. In each case `intrq_o` is 1 one cycle after the first clock edge that sees the new level. Ready changes are found by comparing `ready_i` with its level in the previous cycle.
- R11: Force interrupt condition bit 3 raises `intrq_o` in the next cycle. `intrq_o` then stays high through status reads until the next accepted command write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Host writes the command register this cycle |
| cmd_data | input | 8 | Command byte from the host |
| stat_rd | input | 1 | Host reads the status register this cycle |
| eng_done | input | 1 | Running engine reports completion |
| ready_i | input | 1 | Drive ready level |
| wprot_n | input | 1 | Write protect, active low |
| index_i | input | 1 | Index pulse from the drive |
| track_i | input | 8 | Current track number |
| start_pos | output | 1 | One-cycle start for the type I engine |
| start_sect | output | 1 | One-cycle start for the type II engine |
| start_trk | output | 1 | One-cycle start for the type III engine |
| cmd_byte | output | 8 | Last accepted and started command byte |
| abort_o | output | 1 | One-cycle abort of the running engine |
| busy_o | output | 1 | A command is running |
| intrq_o | output | 1 | Interrupt request |
| wprot_stat | output | 1 | Last transfer was refused by write protect |
| tg43_o | output | 1 | Track beyond 43 at the last transfer command |

## Verification
A wrong busy bit shows one cycle after the next command write. Such a write then either starts while it should be locked out, or is locked out while it should start and produces no strobe. A class decode error sends the strobe to the wrong engine in the cycle after the write. A stale armed condition shows as an interrupt on a ready or index edge that should be quiet, or as a missing one, one cycle after that edge. A lost immediate condition shows at the first status read, which would then drop `intrq_o`.

// File: rtl/fdc_cmd_pkg.sv
package fdc_cmd_pkg;
  typedef enum logic [1:0] {
    KIND_POS  = 2'd0,
    KIND_SECT = 2'd1,
    KIND_TRK  = 2'd2,
    KIND_FORCE = 2'd3
  } cmd_kind_e;

  localparam int CMD_W  = 8;
  localparam int COND_W = 4;
endpackage

// File: rtl/fdc_cmd_classify.sv
module fdc_cmd_classify
  import fdc_cmd_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  output cmd_kind_e        kind,
  output logic             writes_media
);
  always_comb begin
    kind         = KIND_POS;
    writes_media = 1'b0;
    casez (cmd[7:4])
      4'b0???: kind = KIND_POS;
      4'b100?: kind = KIND_SECT;
      4'b101?: begin kind = KIND_SECT; writes_media = 1'b1; end
      4'b1100: kind = KIND_TRK;
      4'b1110: kind = KIND_TRK;
      4'b1111: begin kind = KIND_TRK; writes_media = 1'b1; end
      default: kind = KIND_FORCE;
    endcase
  end
endmodule

// File: rtl/fdc_edge_watch.sv
module fdc_edge_watch #(
  parameter int LINES = 2
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic [LINES-1:0] lvl,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) prev_q <= '0;
    else          prev_q <= lvl;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_edge
    assign rise[g] = lvl[g] & ~prev_q[g];
    assign fall[g] = ~lvl[g] & prev_q[g];
  end
endmodule

// File: rtl/fdc_intr_arm.sv
module fdc_intr_arm
  import fdc_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_q_n,
  input  logic              new_cmd,
  input  logic              new_is_force,
  input  logic [COND_W-1:0] new_cond,
  input  logic              cause,
  input  logic              stat_rd,
  input  logic              rdy_rise,
  input  logic              rdy_fall,
  input  logic              idx_rise,
  output logic              intrq
);
  logic [COND_W-1:0] arm_q, arm_d;
  logic              flag_q, flag_d;
  logic              hit;

  always_comb begin
    arm_d = arm_q;
    if (new_cmd) arm_d = new_is_force ? new_cond : '0;

    hit = cause | (arm_q[0] & rdy_rise) | (arm_q[1] & rdy_fall) |
          (arm_q[2] & idx_rise);

    flag_d = flag_q;
    if (hit)                      flag_d = 1'b1;
    else if (new_cmd || stat_rd)  flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      arm_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      arm_q  <= arm_d;
      flag_q <= flag_d;
    end
  end

  assign intrq = flag_q | arm_q[3];

  // R11: the immediate condition keeps the request up until a new command
  p_imm_hold_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    (intrq && arm_q[3] && !new_cmd) |=> intrq);

  // R10: an armed ready rise produces a request next cycle
  p_rdy_rise_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (arm_q[0] && rdy_rise) |=> intrq);
endmodule

// File: rtl/fdc_cmd_dispatch.sv
module fdc_cmd_dispatch
  import fdc_cmd_pkg::*;
#(
  parameter int TRK_W      = 8,
  parameter int TG43_TRACK = 44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [7:0]       cmd_data,
  input  logic             stat_rd,
  input  logic             eng_done,
  input  logic             ready_i,
  input  logic             wprot_n,
  input  logic             index_i,
  input  logic [TRK_W-1:0] track_i,
  output logic             start_pos,
  output logic             start_sect,
  output logic             start_trk,
  output logic [7:0]       cmd_byte,
  output logic             abort_o,
  output logic             busy_o,
  output logic             intrq_o,
  output logic             wprot_stat,
  output logic             tg43_o
);
  localparam logic [TRK_W-1:0] TG43_LIM = TRK_W'(TG43_TRACK);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  cmd_kind_e kind;
  logic      writes_media;

  fdc_cmd_classify i_classify (
    .cmd          (cmd_data),
    .kind         (kind),
    .writes_media (writes_media)
  );

  logic [1:0] lvl_rise, lvl_fall;
  fdc_edge_watch #(.LINES(2)) i_edges (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .lvl     ({index_i, ready_i}),
    .rise    (lvl_rise),
    .fall    (lvl_fall)
  );

  logic       busy_q, busy_d;
  logic [2:0] start_q, start_d;
  logic [7:0] cmd_q, cmd_d;
  logic       abort_q, abort_d;
  logic       tg43_q, tg43_d;
  logic       wp_q, wp_d;

  logic is_force, take, take_norm, xfer, rej_rdy, rej_wp, go, done_evt;

  always_comb begin
    is_force  = (kind == KIND_FORCE);
    take      = cmd_we && (is_force || !busy_q);
    take_norm = take && !is_force;
    xfer      = (kind == KIND_SECT) || (kind == KIND_TRK);
    rej_rdy   = take_norm && xfer && !ready_i;
    rej_wp    = take_norm && xfer && ready_i && writes_media && !wprot_n;
    go        = take_norm && !rej_rdy && !rej_wp;
    done_evt  = busy_q && eng_done && !(take && is_force);

    busy_d = busy_q;
    if (take && is_force) busy_d = 1'b0;
    else if (go)          busy_d = 1'b1;
    else if (done_evt)    busy_d = 1'b0;

    start_d = {go && (kind == KIND_TRK), go && (kind == KIND_SECT),
               go && (kind == KIND_POS)};
    cmd_d   = go ? cmd_data : cmd_q;
    abort_d = take && is_force && busy_q;
    tg43_d  = (take_norm && xfer) ? (track_i >= TG43_LIM) : tg43_q;
    wp_d    = take_norm ? rej_wp : wp_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      busy_q  <= 1'b0;
      start_q <= '0;
      cmd_q   <= '0;
      abort_q <= 1'b0;
      tg43_q  <= 1'b0;
      wp_q    <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      start_q <= start_d;
      cmd_q   <= cmd_d;
      abort_q <= abort_d;
      tg43_q  <= tg43_d;
      wp_q    <= wp_d;
    end
  end

  fdc_intr_arm i_intr (
    .clk          (clk),
    .rst_q_n      (rst_q_n),
    .new_cmd      (take),
    .new_is_force (is_force),
    .new_cond     (cmd_data[COND_W-1:0]),
    .cause        (done_evt | rej_rdy | rej_wp),
    .stat_rd      (stat_rd),
    .rdy_rise     (lvl_rise[0]),
    .rdy_fall     (lvl_fall[0]),
    .idx_rise     (lvl_rise[1]),
    .intrq        (intrq_o)
  );

  assign start_pos  = start_q[0];
  assign start_sect = start_q[1];
  assign start_trk  = start_q[2];
  assign cmd_byte   = cmd_q;
  assign abort_o    = abort_q;
  assign busy_o     = busy_q;
  assign wprot_stat = wp_q;
  assign tg43_o     = tg43_q;

  // R1: writes other than force interrupt are locked out while busy
  p_busy_lock_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy_o && cmd_we && cmd_data[7:4] != 4'b1101) |=>
      (!start_pos && !start_sect && !start_trk && busy_o));

  // R2: at most one engine is started in a cycle
  p_one_start_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({start_pos, start_sect, start_trk}));

  // R3: transfer command with drive not ready ends at once
  p_not_ready_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!busy_o && cmd_we && cmd_data[7] && cmd_data[7:4] != 4'b1101 && !ready_i) |=>
      (intrq_o && !busy_o && !start_sect && !start_trk));

  // R5: refused write sets the protect status with a request
  p_wprot_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!busy_o && cmd_we && ready_i && !wprot_n &&
     (cmd_data[7:5] == 3'b101 || cmd_data[7:4] == 4'b1111)) |=>
      (wprot_stat && intrq_o && !busy_o));

  // R7: completion drops busy and raises the request
  p_done_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy_o && eng_done && !cmd_we) |=> (!busy_o && intrq_o));

  // R9: force interrupt on a running command aborts it
  p_force_abort_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy_o && cmd_we && cmd_data[7:4] == 4'b1101) |=> (abort_o && !busy_o));
endmodule

// File: tb/test_fdc_cmd_dispatch.sv
module test_fdc_cmd_dispatch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_data = '0;
  logic       stat_rd = 1'b0;
  logic       eng_done = 1'b0;
  logic       ready_i = 1'b1;
  logic       wprot_n = 1'b1;
  logic       index_i = 1'b0;
  logic [7:0] track_i = '0;
  logic       start_pos, start_sect, start_trk, abort_o, busy_o, intrq_o;
  logic       wprot_stat, tg43_o;
  logic [7:0] cmd_byte;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  fdc_cmd_dispatch i_fdc_cmd_dispatch (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .stat_rd(stat_rd), .eng_done(eng_done), .ready_i(ready_i),
    .wprot_n(wprot_n), .index_i(index_i), .track_i(track_i),
    .start_pos(start_pos), .start_sect(start_sect), .start_trk(start_trk),
    .cmd_byte(cmd_byte), .abort_o(abort_o), .busy_o(busy_o),
    .intrq_o(intrq_o), .wprot_stat(wprot_stat), .tg43_o(tg43_o)
  );

  // fields: cmd, track, ready, wprot_n, start{trk,sect,pos}, busy, intrq, wp, tg43, pad
  localparam int NV = 12;
  localparam logic [31:0] VEC [NV] = '{
    {8'h03, 8'd10, 1'b1, 1'b1, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 7'd0},
    {8'h1A, 8'd50, 1'b0, 1'b1, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 7'd0},
    {8'h80, 8'd50, 1'b1, 1'b1, 3'b010, 1'b1, 1'b0, 1'b0, 1'b1, 7'd0},
    {8'h88, 8'd43, 1'b0, 1'b1, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 7'd0},
    {8'hA0, 8'd44, 1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 7'd0},
    {8'hF0, 8'd20, 1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 7'd0},
    {8'hC0, 8'd60, 1'b1, 1'b0, 3'b100, 1'b1, 1'b0, 1'b0, 1'b1, 7'd0},
    {8'hE4, 8'd44, 1'b1, 1'b1, 3'b100, 1'b1, 1'b0, 1'b0, 1'b1, 7'd0},
    {8'h54, 8'd0,  1'b1, 1'b1, 3'b001, 1'b1, 1'b0, 1'b0, 1'b1, 7'd0},
    {8'hB2, 8'd43, 1'b1, 1'b1, 3'b010, 1'b1, 1'b0, 1'b0, 1'b0, 7'd0},
    {8'hF0, 8'd80, 1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 1'b1, 7'd0},
    {8'h7F, 8'd80, 1'b0, 1'b0, 3'b001, 1'b1, 1'b0, 1'b0, 1'b1, 7'd0}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 8:    return "R2 R7 type I start";
      1, 11:   return "R4 R6 type I without ready";
      2, 9:    return "R2 R6 type II start";
      3, 10:   return "R3 R6 not ready reject";
      4, 5:    return "R5 R6 write protect reject";
      default: return "R2 R5 R6 type III start";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic write_cmd(input logic [7:0] c);
    cmd_we = 1'b1; cmd_data = c;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic pulse_done();
    eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic pulse_rd();
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // reset state
    chk("R7 reset busy", 32'(busy_o), 0);
    chk("R8 reset intrq", 32'(intrq_o), 0);
    chk("R6 reset tg43", 32'(tg43_o), 0);
    chk("R2 reset strobes", 32'({start_trk, start_sect, start_pos}), 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      track_i = v[23:16]; ready_i = v[15]; wprot_n = v[14];
      write_cmd(v[31:24]);
      chk(vec_tag(i), 32'({start_trk, start_sect, start_pos, busy_o, intrq_o,
                           wprot_stat, tg43_o}), 32'(v[13:7]));
      pulse_done();
      pulse_rd();
    end

    ready_i = 1'b1; wprot_n = 1'b1;

    // R1 lockout, R2 held byte, R7 completion, R8 clearing
    write_cmd(8'h03);
    write_cmd(8'h80);
    chk("R1 locked write no strobe", 32'({start_trk, start_sect, start_pos}), 0);
    chk("R1 locked write busy kept", 32'(busy_o), 1);
    chk("R2 R1 held command byte", 32'(cmd_byte), 32'h03);
    pulse_done();
    chk("R7 done busy", 32'(busy_o), 0);
    chk("R7 done intrq", 32'(intrq_o), 1);
    write_cmd(8'h03);
    chk("R8 command write clears intrq", 32'({busy_o, intrq_o}), 32'b10);
    pulse_done();
    pulse_rd();
    chk("R8 status read clears intrq", 32'(intrq_o), 0);

    // R9 abort without interrupt
    write_cmd(8'h03);
    write_cmd(8'hD0);
    chk("R9 abort pulse", 32'(abort_o), 1);
    chk("R9 busy cleared", 32'(busy_o), 0);
    chk("R9 no intrq", 32'(intrq_o), 0);
    cyc(1);
    chk("R9 abort one cycle", 32'(abort_o), 0);

    // R10 ready rise
    ready_i = 1'b0;
    cyc(1);
    write_cmd(8'hD1);
    chk("R10 armed quiet", 32'(intrq_o), 0);
    ready_i = 1'b1;
    cyc(1);
    chk("R10 ready rise intrq", 32'(intrq_o), 1);
    pulse_rd();
    // R10 ready fall
    write_cmd(8'hD2);
    chk("R10 fall armed quiet", 32'(intrq_o), 0);
    ready_i = 1'b0;
    cyc(1);
    chk("R10 ready fall intrq", 32'(intrq_o), 1);
    pulse_rd();
    // R10 index
    write_cmd(8'hD4);
    index_i = 1'b1;
    cyc(1);
    chk("R10 index intrq", 32'(intrq_o), 1);
    index_i = 1'b0;
    pulse_rd();
    chk("R10 cleared after read", 32'(intrq_o), 0);

    // R11 immediate
    write_cmd(8'hD8);
    chk("R11 immediate intrq", 32'(intrq_o), 1);
    pulse_rd();
    chk("R11 survives status read", 32'(intrq_o), 1);
    write_cmd(8'h03);
    chk("R11 cleared by next command", 32'({busy_o, intrq_o}), 32'b10);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule